// File: doc/BRIEF.md
# Serial converter read sequencer

This block is the host-side master for a 16-bit successive-approximation converter whose serial port runs in three-wire chip-select mode with no busy flag. One pulse on `start_i` runs a full cycle. The convert-select line drops for a short gap and then rises, which starts the conversion. It stays high for the worst-case conversion time, so the converter never signals busy. The line then falls, the controller takes the most significant bit, and it clocks out the remaining bits on a serial clock that the controller generates itself.

Every interval is a parameter counted in system-clock cycles: the gap before the conversion edge, the conversion time, the delay between the select line falling and the first bit becoming valid, the half period of the serial clock, and the hold margin after each serial-clock falling edge. Once the last bit is taken, the select line goes high again, which releases the converter's data line. The assembled word is presented with a one-cycle strobe, and the block returns to idle, ready for the next start.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is held and on leaving it, `cnv_o` is 1, `sck_o` is 0, `valid_o` is 0 and `data_o` is all zeros.
- R2: A start seen in idle drives `cnv_o` low for exactly GAP_CYC cycles and then high. That rising edge begins a conversion.
- R3: The conversion rising edge is followed by exactly CONV_CYC cycles with `cnv_o` high before it falls.
- R4: `sck_o` is 0 in every cycle in which `cnv_o` is 1.
- R5: The first data bit (the MSB) is sampled from `sdo_i` after `cnv_o` has been low for EN_CYC cycles. This happens before any serial-clock edge, and `sck_o` first rises in that same clock edge.
- R6: Each frame has exactly DATA_W-1 rising edges of `sck_o`, and each high phase lasts SCK_HALF cycles. Each later bit is sampled HOLD_CYC+1 cycles after a falling edge of `sck_o`.
- R7: `data_o` holds the DATA_W sampled bits with the first sampled bit at the most significant position (bit DATA_W-1) and the last at bit 0.
- R8: In the clock edge that samples the last bit, `cnv_o` rises and `valid_o` goes to 1 for exactly one cycle, with the new word on `data_o`.
- R9: A start that arrives while a frame is in progress has no effect. The frame keeps its timing, only one `valid_o` pulse results, and `cnv_o` stays high in idle afterwards.
- R10: `data_o` changes only in a cycle in which `valid_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one convert-and-read frame |
| sdo_i | input | 1 | Serial data from the converter |
| cnv_o | output | 1 | Convert-select line to the converter |
| sck_o | output | 1 | Serial clock to the converter |
| data_o | output | DATA_W | Last result word, MSB first on the wire |
| valid_o | output | 1 | One-cycle strobe marking a new `data_o` |

## Verification
The assertions check on every cycle that the serial clock stays low while the select line is high and that the conversion high phase lasts exactly CONV_CYC cycles. They also check that no frame produces more than DATA_W-1 serial-clock rising edges, that the result strobe is a single cycle that coincides with the select line rising, and that the result word holds between strobes. A behavioural converter model in the bench shifts a known word out on the select-line fall and on each serial-clock fall. Only that model's scenarios can show that the bits arrive in the right order, that the enable delay and the clock widths match their parameters, and that a start request arriving mid-frame is dropped.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_CONV,
    ST_ENW,
    ST_HI,
    ST_LO
  } rd_state_t;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int GAP_CYC  = 2,
  parameter int CONV_CYC = 50,
  parameter int EN_CYC   = 2,
  parameter int SCK_HALF = 2,
  parameter int HOLD_CYC = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic cnv_o,
  output logic sck_o,
  output logic cap_o,
  output logic last_o
);

  localparam int MAXC   = max_of4(GAP_CYC, CONV_CYC, EN_CYC, SCK_HALF);
  localparam int CNT_W  = $clog2(MAXC + 1);
  localparam int BIT_W  = $clog2(DATA_W + 1);
  localparam int CAP_AT = (HOLD_CYC < SCK_HALF) ? HOLD_CYC : SCK_HALF - 1;

  localparam logic [CNT_W-1:0] GAP_END  = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] CONV_END = CNT_W'(CONV_CYC - 1);
  localparam logic [CNT_W-1:0] EN_END   = CNT_W'(EN_CYC - 1);
  localparam logic [CNT_W-1:0] HALF_END = CNT_W'(SCK_HALF - 1);
  localparam logic [CNT_W-1:0] CAP_TICK = CNT_W'(CAP_AT);
  localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(DATA_W - 1);

  rd_state_t        st;
  logic [CNT_W-1:0] tick;
  logic [BIT_W-1:0] nbits;

  // sampling strobe: MSB at end of enable wait, later bits after the hold margin
  always_comb begin
    cap_o  = ((st == ST_ENW) && (tick == EN_END)) ||
             ((st == ST_LO)  && (tick == CAP_TICK));
    last_o = cap_o && (st == ST_LO) && (nbits == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      tick  <= '0;
      nbits <= '0;
      cnv_o <= 1'b1;
      sck_o <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          tick <= '0;
          if (start_i) begin
            st    <= ST_GAP;
            cnv_o <= 1'b0;
          end
        end
        ST_GAP: begin
          if (tick == GAP_END) begin
            st    <= ST_CONV;
            tick  <= '0;
            cnv_o <= 1'b1;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        ST_CONV: begin
          if (tick == CONV_END) begin
            st    <= ST_ENW;
            tick  <= '0;
            cnv_o <= 1'b0;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        ST_ENW: begin
          if (tick == EN_END) begin
            st    <= ST_HI;
            tick  <= '0;
            sck_o <= 1'b1;
            nbits <= BIT_W'(1);
          end else begin
            tick <= tick + 1'b1;
          end
        end
        ST_HI: begin
          if (tick == HALF_END) begin
            st    <= ST_LO;
            tick  <= '0;
            sck_o <= 1'b0;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        ST_LO: begin
          if (cap_o) nbits <= nbits + 1'b1;
          if (last_o) begin
            st    <= ST_IDLE;
            tick  <= '0;
            nbits <= '0;
            cnv_o <= 1'b1;
          end else if (tick == HALF_END) begin
            st    <= ST_HI;
            tick  <= '0;
            sck_o <= 1'b1;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        default: begin
          st    <= ST_IDLE;
          tick  <= '0;
          cnv_o <= 1'b1;
          sck_o <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sdo_i,
  input  logic              cap_i,
  input  logic              last_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);

  logic [DATA_W-2:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (cap_i) begin
        sh <= {sh[DATA_W-3:0], sdo_i};
      end
      if (last_i) begin
        data_o  <= {sh, sdo_i};
        valid_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl #(
  parameter int DATA_W   = 16,
  parameter int GAP_CYC  = 2,
  parameter int CONV_CYC = 50,
  parameter int EN_CYC   = 2,
  parameter int SCK_HALF = 2,
  parameter int HOLD_CYC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              sdo_i,
  output logic              cnv_o,
  output logic              sck_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);

  logic cap;
  logic last;

  adc_rd_seq #(
    .DATA_W  (DATA_W),
    .GAP_CYC (GAP_CYC),
    .CONV_CYC(CONV_CYC),
    .EN_CYC  (EN_CYC),
    .SCK_HALF(SCK_HALF),
    .HOLD_CYC(HOLD_CYC)
  ) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start_i(start_i),
    .cnv_o  (cnv_o),
    .sck_o  (sck_o),
    .cap_o  (cap),
    .last_o (last)
  );

  adc_rd_shift #(
    .DATA_W(DATA_W)
  ) u_shift (
    .clk    (clk),
    .rst    (rst),
    .sdo_i  (sdo_i),
    .cap_i  (cap),
    .last_i (last),
    .data_o (data_o),
    .valid_o(valid_o)
  );

endmodule

// File: rtl/adc_rd_chk.sv
module adc_rd_chk #(
  parameter int DATA_W   = 16,
  parameter int CONV_CYC = 50
) (
  input logic              clk,
  input logic              rst,
  input logic              cnv_o,
  input logic              sck_o,
  input logic [DATA_W-1:0] data_o,
  input logic              valid_o
);

  localparam int CW = $clog2(CONV_CYC + 2);
  localparam int SW = $clog2(DATA_W + 1);

  logic          cnv_q;
  logic          sck_q;
  logic          in_conv;
  logic [CW-1:0] hi_cnt;
  logic [SW-1:0] rise_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnv_q    <= 1'b1;
      sck_q    <= 1'b0;
      in_conv  <= 1'b0;
      hi_cnt   <= '0;
      rise_cnt <= '0;
    end else begin
      cnv_q <= cnv_o;
      sck_q <= sck_o;
      if (cnv_o && !cnv_q && !valid_o) begin
        in_conv <= 1'b1;
        hi_cnt  <= CW'(1);
      end else if (in_conv && cnv_o) begin
        hi_cnt <= hi_cnt + 1'b1;
      end else if (in_conv && !cnv_o) begin
        in_conv <= 1'b0;
      end
      if (!cnv_o && cnv_q) rise_cnt <= '0;
      else if (sck_o && !sck_q) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  // R4
  sck_idle_chk: assert property (@(posedge clk) disable iff (rst) cnv_o |-> !sck_o);

  // R3
  conv_len_chk: assert property (@(posedge clk) disable iff (rst)
    (in_conv && !cnv_o) |-> (hi_cnt == CW'(CONV_CYC)));

  // R6
  sck_count_chk: assert property (@(posedge clk) disable iff (rst)
    rise_cnt <= SW'(DATA_W - 1));

  // R8
  valid_edge_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (cnv_o && !cnv_q));

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst) valid_o |=> !valid_o);

  // R10
  data_hold_chk: assert property (@(posedge clk) disable iff (rst) !valid_o |-> $stable(data_o));

endmodule

bind adc_rd_ctrl adc_rd_chk #(
  .DATA_W  (DATA_W),
  .CONV_CYC(CONV_CYC)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .cnv_o  (cnv_o),
  .sck_o  (sck_o),
  .data_o (data_o),
  .valid_o(valid_o)
);

// File: tb/adc_rd_ctrl_bench.sv
module adc_rd_ctrl_bench;

  localparam int DW = 16;
  localparam int G  = 2;
  localparam int C  = 7;
  localparam int E  = 3;
  localparam int H  = 3;
  localparam int M  = 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic          sdo_i = 1'b0;
  logic          cnv_o;
  logic          sck_o;
  logic [DW-1:0] data_o;
  logic          valid_o;

  int total = 0;
  int fails = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  adc_rd_ctrl #(
    .DATA_W(DW), .GAP_CYC(G), .CONV_CYC(C), .EN_CYC(E), .SCK_HALF(H), .HOLD_CYC(M)
  ) u_adc_rd_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .sdo_i(sdo_i),
    .cnv_o(cnv_o), .sck_o(sck_o), .data_o(data_o), .valid_o(valid_o)
  );

  // converter model: word latched on the conversion edge, shifted out MSB first
  logic [DW-1:0] model_pat = '0;
  logic [DW-1:0] conv_word = '0;
  int            bit_i = 0;

  always @(posedge cnv_o) conv_word = model_pat;
  always @(negedge cnv_o) begin
    bit_i = DW - 1;
    #2 sdo_i = conv_word[bit_i];
  end
  always @(negedge sck_o) begin
    if (!cnv_o && bit_i > 0) begin
      bit_i = bit_i - 1;
      #2 sdo_i = conv_word[bit_i];
    end
  end

  // port monitor
  bit mon_on = 1'b0;
  int phase, gap_n, conv_n, en_n, rises, hi_n, sck_bad, valids;
  logic prev_sck = 1'b0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (cnv_o && sck_o) sck_bad++;
      if (valid_o) valids++;
      case (phase)
        0: if (!cnv_o) gap_n++; else if (gap_n > 0) begin phase = 1; conv_n = 1; end
        1: if (cnv_o) conv_n++; else begin phase = 2; en_n = 1; end
        default: begin
          if (sck_o && !prev_sck) rises++;
          if (sck_o) hi_n++;
          if (rises == 0 && !sck_o && !cnv_o) en_n++;
        end
      endcase
    end
    prev_sck = sck_o;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      total++; fails++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [DW-1:0] pat, input bit poke);
    bit got;
    model_pat = pat;
    phase = 0; gap_n = 0; conv_n = 0; en_n = 0; rises = 0; hi_n = 0;
    sck_bad = 0; valids = 0;
    @(negedge clk); mon_on = 1'b1; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    got = 1'b0;
    for (int i = 0; i < 2000 && !got; i++) begin
      @(negedge clk);
      start_i = (poke && (i == G + 2 || i == G + C + E + 4)) ? 1'b1 : 1'b0;
      if (valid_o) got = 1'b1;
    end
    start_i = 1'b0;
    chk(got, "R8 valid seen", got, 1);
    chk(data_o == pat, "R7 word", data_o, pat);
    chk(cnv_o == 1'b1, "R8 cnv high with valid", cnv_o, 1);
    @(negedge clk);
    chk(valid_o == 1'b0, "R8 one-cycle valid", valid_o, 0);
    chk(gap_n == G, "R2 gap", gap_n, G);
    chk(conv_n == C, "R3 conv high", conv_n, C);
    chk(en_n == E, "R5 enable delay", en_n, E);
    chk(rises == DW - 1, "R6 sck rises", rises, DW - 1);
    chk(hi_n == (DW - 1) * H, "R6 sck high time", hi_n, (DW - 1) * H);
    chk(sck_bad == 0, "R4 sck low while cnv high", sck_bad, 0);
    repeat (6) @(negedge clk);
    chk(valids == 1, "R9 single result", valids, 1);
    chk(cnv_o == 1'b1 && !sck_o, "R9 idle after frame", {cnv_o, sck_o}, 2);
    chk(data_o == pat, "R10 word held", data_o, pat);
    mon_on = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cnv_o == 1'b1, "R1 cnv reset", cnv_o, 1);
    chk(sck_o == 1'b0, "R1 sck reset", sck_o, 0);
    chk(valid_o == 1'b0, "R1 valid reset", valid_o, 0);
    chk(data_o == '0, "R1 data reset", data_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(cnv_o == 1'b1 && !valid_o && data_o == '0, "R1 after reset", cnv_o, 1);

    frame(16'h0000, 1'b0);
    frame(16'hFFFF, 1'b0);
    frame(16'hAAAA, 1'b0);
    frame(16'h5555, 1'b0);
    frame(16'h1234, 1'b1);   // R9: start pulses during gap/conv and read
    frame(16'h8001, 1'b1);
    for (int k = 0; k < DW; k++) frame(16'(1 << k), 1'b0);
    for (int k = 0; k < DW; k++) frame(~16'(1 << k), 1'b0);
    for (int k = 0; k < 16; k++) frame(16'(k * 16'h1357 + 16'h0F0F), k[0]);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule